// File: doc/BRIEF.md
# Speed-Aware I2C Clock Waveform Generator

This block turns a system clock into a continuous I2C clock line whose low and high phases are deliberately unequal. Software-facing logic supplies the desired bus period in system-clock cycles and a speed class. The block derives a low-phase length and a high-phase length from the minimum low and high times that class allows, so the low phase always gets the larger share. This avoids the trap of an even split at 400 kHz, which leaves the low phase shorter than the bus permits.

On enable, or whenever the period or speed class changes, a short serial division computes the two phase lengths. While that runs the line is released. Once `ready` rises, the line alternates between driven-low and released for exactly those counts, starting with the low phase. One-cycle strobes mark each driven falling edge and each phase-boundary rising edge, so a byte engine can later sequence data against them. Start/stop conditions, data shifting, arbitration and the high-speed handshake are not part of this block.

Top module: `i2c_scl_gen`

## Requirements
- R1: After reset, and whenever `en` is low, `scl_oe` is 0 (line released), `ready` is 0, both strobes are 0, and `low_cnt`/`high_cnt` read 0.
- R2: With `mode` = 0 (standard), `low_cnt` = ceil(P*47/87) and `high_cnt` = P - `low_cnt`, where P is the effective period.
- R3: With `mode` = 1 (fast), `low_cnt` = ceil(P*13/19); for P = 125 this gives 86 low and 39 high, never an equal split.
- R4: With `mode` = 2 or 3 (high-speed), `low_cnt` = ceil(P*2/3).
- R5: Once running, `scl_oe` is 1 for exactly `low_cnt` cycles, then 0 for exactly `high_cnt` cycles, repeating. The two counts sum to P, and the first phase after `ready` is low.
- R6: A programmed `period` below 3 is treated as 3, and `low_cnt` is limited to P - 1, so each phase lasts at least one cycle.
- R7: `ready` rises only after the counts are computed, and `scl_oe` is never 1 while `ready` is 0.
- R8: If `period` or `mode` changes while enabled, the next cycle shows `ready` = 0 and `scl_oe` = 0, and counts for the new settings are then computed and used.
- R9: `fall_stb` is 1 for exactly the first cycle of each low phase, and `rise_stb` is 1 for exactly the first cycle of each high phase. Releasing the line because of disable or recompute raises no strobe.
- R10: Dropping `en` releases the line and clears `ready` in the next cycle, even in the middle of a low phase.
- R11: While `ready` is 1, `low_cnt` >= `high_cnt` and both are nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable |
| period | input | PW | Desired bus period in system-clock cycles |
| mode | input | 2 | Speed class: 0 standard, 1 fast, 2/3 high-speed |
| scl_oe | output | 1 | 1 drives the line low, 0 releases it |
| ready | output | 1 | Phase counts valid and waveform running |
| fall_stb | output | 1 | First cycle of a low phase |
| rise_stb | output | 1 | First cycle of a high phase |
| low_cnt | output | PW | Computed low-phase length in cycles |
| high_cnt | output | PW | Computed high-phase length in cycles |

## Verification
Every output is registered, so disable and setting changes show up one clock edge after the input moves. The bench drives inputs on the falling edge and checks at the next falling edge. The length of the count computation is not fixed in the checks. Instead the bench waits for the first `fall_stb`, confirming along the way that the line is never driven before `ready`. From that strobe it counts falling-edge samples of `scl_oe` to measure each phase, checking the matching strobe on the first sample of each phase.

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [PW-1:0] period,
  input  logic [1:0]    mode,
  output logic          scl_oe,
  output logic          ready,
  output logic          fall_stb,
  output logic          rise_stb,
  output logic [PW-1:0] low_cnt,
  output logic [PW-1:0] high_cnt
);
  localparam int DW = PW + 7;
  localparam int SW = $clog2(DW + 1);

  typedef enum logic [1:0] {S_IDLE, S_CALC, S_RUN} st_t;

  st_t           state;
  logic [PW-1:0] lat_per, eff_per, ph_cnt;
  logic [1:0]    lat_mode;
  logic [DW-1:0] dvd, quo;
  logic [7:0]    rem, den_r;
  logic [SW-1:0] step;

  logic [5:0]    num;
  logic [7:0]    den;
  logic [PW-1:0] per_c;
  logic [DW-1:0] dvd_init;
  logic          chg, start;

  always_comb begin
    case (mode)
      2'd0:    begin num = 6'd47; den = 8'd87; end
      2'd1:    begin num = 6'd13; den = 8'd19; end
      default: begin num = 6'd2;  den = 8'd3;  end
    endcase
  end

  assign per_c    = (period < PW'(3)) ? PW'(3) : period;
  assign dvd_init = DW'(per_c) * DW'(num) + DW'(den) - DW'(1);
  assign chg      = (period != lat_per) || (mode != lat_mode);
  assign start    = en && ((state == S_IDLE) || chg);

  logic [7:0]    rem_try, rem_nxt;
  logic          ge;
  logic [DW-1:0] quo_nxt;
  logic [PW-1:0] low_fin;

  assign rem_try = {rem[6:0], dvd[DW-1]};
  assign ge      = rem_try >= den_r;
  assign rem_nxt = ge ? rem_try - den_r : rem_try;
  assign quo_nxt = {quo[DW-2:0], ge};
  assign low_fin = (quo_nxt > DW'(eff_per - PW'(1))) ? eff_per - PW'(1) : quo_nxt[PW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      lat_per  <= '0;
      lat_mode <= '0;
      eff_per  <= '0;
      dvd      <= '0;
      quo      <= '0;
      rem      <= '0;
      den_r    <= '0;
      step     <= '0;
      ph_cnt   <= '0;
      scl_oe   <= 1'b0;
      ready    <= 1'b0;
      fall_stb <= 1'b0;
      rise_stb <= 1'b0;
      low_cnt  <= '0;
      high_cnt <= '0;
    end else begin
      fall_stb <= 1'b0;
      rise_stb <= 1'b0;
      if (!en) begin
        state    <= S_IDLE;
        ph_cnt   <= '0;
        scl_oe   <= 1'b0;
        ready    <= 1'b0;
        low_cnt  <= '0;
        high_cnt <= '0;
      end else if (start) begin
        state    <= S_CALC;
        lat_per  <= period;
        lat_mode <= mode;
        eff_per  <= per_c;
        dvd      <= dvd_init;
        den_r    <= den;
        quo      <= '0;
        rem      <= '0;
        step     <= '0;
        ph_cnt   <= '0;
        scl_oe   <= 1'b0;
        ready    <= 1'b0;
        low_cnt  <= '0;
        high_cnt <= '0;
      end else begin
        case (state)
          S_CALC: begin
            rem  <= rem_nxt;
            quo  <= quo_nxt;
            dvd  <= {dvd[DW-2:0], 1'b0};
            step <= step + SW'(1);
            if (step == SW'(DW - 1)) begin
              low_cnt  <= low_fin;
              high_cnt <= eff_per - low_fin;
              ready    <= 1'b1;
              scl_oe   <= 1'b1;
              fall_stb <= 1'b1;
              ph_cnt   <= '0;
              state    <= S_RUN;
            end
          end
          S_RUN: begin
            if (scl_oe) begin
              if (ph_cnt == low_cnt - PW'(1)) begin
                scl_oe   <= 1'b0;
                rise_stb <= 1'b1;
                ph_cnt   <= '0;
              end else begin
                ph_cnt <= ph_cnt + PW'(1);
              end
            end else begin
              if (ph_cnt == high_cnt - PW'(1)) begin
                scl_oe   <= 1'b1;
                fall_stb <= 1'b1;
                ph_cnt   <= '0;
              end else begin
                ph_cnt <= ph_cnt + PW'(1);
              end
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_scl_gen_chk.sv
module i2c_scl_gen_chk #(
  parameter int PW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          scl_oe,
  input logic          ready,
  input logic          fall_stb,
  input logic          rise_stb,
  input logic [PW-1:0] low_cnt,
  input logic [PW-1:0] high_cnt
);
  p_no_drive_unready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |-> ready);

  p_off_releases_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_oe && !ready));

  p_low_share_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (low_cnt >= high_cnt && high_cnt != '0));

  p_fall_marks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> fall_stb);

  p_fall_only_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> $rose(scl_oe));

  p_rise_only_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> $fell(scl_oe));

  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(fall_stb && rise_stb));

  p_idle_counts_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (low_cnt == '0 && high_cnt == '0));
endmodule

bind i2c_scl_gen i2c_scl_gen_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .scl_oe(scl_oe), .ready(ready),
  .fall_stb(fall_stb), .rise_stb(rise_stb), .low_cnt(low_cnt), .high_cnt(high_cnt)
);

// File: tb/i2c_scl_gen_tb.sv
module i2c_scl_gen_tb;
  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [PW-1:0] period = '0;
  logic [1:0]    mode = '0;
  logic          scl_oe, ready, fall_stb, rise_stb;
  logic [PW-1:0] low_cnt, high_cnt;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  i2c_scl_gen #(.PW(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .period(period), .mode(mode),
    .scl_oe(scl_oe), .ready(ready), .fall_stb(fall_stb), .rise_stb(rise_stb),
    .low_cnt(low_cnt), .high_cnt(high_cnt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_low(input int p, input int m);
    int pc, nu, de, lo;
    pc = (p < 3) ? 3 : p;
    if (m == 0) begin nu = 47; de = 87; end
    else if (m == 1) begin nu = 13; de = 19; end
    else begin nu = 2; de = 3; end
    lo = (pc * nu + de - 1) / de;
    if (lo > pc - 1) lo = pc - 1;
    return lo;
  endfunction

  task automatic wait_first_fall(input string req);
    int n = 0;
    bit early = 0;
    while (!fall_stb && n < 5000) begin
      if (scl_oe && !ready) early = 1;
      @(negedge clk);
      n++;
    end
    chk(!early, "R7 drive before ready", int'(early), 0);
    chk(fall_stb && ready && scl_oe, req, int'({fall_stb, ready, scl_oe}), 7);
  endtask

  task automatic measure(input int p, input int m, input string req);
    int lo, hi, pc, n, k;
    pc = (p < 3) ? 3 : p;
    lo = exp_low(p, m);
    hi = pc - lo;
    chk(int'(low_cnt) == lo, req, int'(low_cnt), lo);
    chk(int'(high_cnt) == hi, req, int'(high_cnt), hi);
    for (int rep = 0; rep < 2; rep++) begin
      n = 1;
      @(negedge clk);
      while (scl_oe && n < 100000) begin n++; @(negedge clk); end
      chk(n == lo, {req, " R5 low phase"}, n, lo);
      chk(rise_stb == 1'b1, "R9 rise strobe", int'(rise_stb), 1);
      k = 1;
      @(negedge clk);
      while (!scl_oe && k < 100000) begin k++; @(negedge clk); end
      chk(k == hi, {req, " R5 high phase"}, k, hi);
      chk(fall_stb == 1'b1, "R9 fall strobe", int'(fall_stb), 1);
    end
  endtask

  task automatic run_cfg(input int p, input int m, input string req);
    @(negedge clk);
    en = 1'b0;
    repeat (2) @(negedge clk);
    period = PW'(p);
    mode = 2'(m);
    en = 1'b1;
    @(negedge clk);
    wait_first_fall({req, " R7 start"});
    measure(p, m, req);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!scl_oe && !ready && !fall_stb && !rise_stb, "R1 reset outputs",
        int'({scl_oe, ready, fall_stb, rise_stb}), 0);
    chk(low_cnt == '0 && high_cnt == '0, "R1 reset counts", int'(low_cnt), 0);
  endtask

  task automatic t_change();
    run_cfg(125, 1, "R3 fast base");
    repeat (5) @(negedge clk);
    mode = 2'd0;
    @(negedge clk);
    chk(!ready && !scl_oe, "R8 recompute release", int'({ready, scl_oe}), 0);
    chk(!rise_stb, "R9 no strobe on recompute", int'(rise_stb), 0);
    wait_first_fall("R8 restart");
    measure(125, 0, "R8 new counts");
  endtask

  task automatic t_disable();
    run_cfg(30, 2, "R4 hs base");
    repeat (3) @(negedge clk);
    chk(scl_oe == 1'b1, "R10 in low phase", int'(scl_oe), 1);
    en = 1'b0;
    @(negedge clk);
    chk(!scl_oe && !ready, "R10 released", int'({scl_oe, ready}), 0);
    chk(!rise_stb && !fall_stb, "R9 no strobe on disable", int'({rise_stb, fall_stb}), 0);
    chk(low_cnt == '0 && high_cnt == '0, "R1 counts cleared", int'(low_cnt), 0);
    repeat (20) @(negedge clk);
    chk(!scl_oe, "R1 stays released", int'(scl_oe), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    run_cfg(500, 0, "R2 standard");
    run_cfg(125, 1, "R3 fast");
    chk(exp_low(125, 1) == 86, "R3 fast share", exp_low(125, 1), 86);
    run_cfg(10, 1, "R3 fast short");
    run_cfg(30, 2, "R4 hs");
    run_cfg(31, 3, "R4 hs alt code");
    run_cfg(1, 0, "R6 clamp standard");
    run_cfg(2, 1, "R6 clamp fast");
    run_cfg(0, 2, "R6 clamp hs");
    chk(int'(low_cnt) >= int'(high_cnt), "R11 low share", int'(low_cnt), int'(high_cnt));
    t_change();
    t_disable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule